// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage of a 32-bit in-order pipeline and picks the next fetch address. Each cycle it takes the fetch PC and reads two direct-mapped tables with it. The first is a table of 2-bit saturating direction counters. The second is a small tagged cache of branch targets. If the target cache hits and the counter leans taken, fetch is steered to the cached target in the same cycle. Otherwise fetch continues at PC+4.

Further down the pipe, each executed branch comes back on the resolve port. It carries the branch PC, the actual direction, the actual target and the next PC that fetch followed after that branch. On every valid resolve the direction counter trains. A taken resolve also fills or refreshes the target entry. If the path fetch followed differs from the real one, the block raises `flush` in that same cycle and replaces the fetch next PC with the correct address. A taken branch whose target was not cached therefore costs one redirect.

Each direction counter is a four-state machine. The states are strong-not-taken (`CTR_STRONG_NT`, 00), weak-not-taken (`CTR_WEAK_NT`, 01), weak-taken (`CTR_WEAK_T`, 10) and strong-taken (`CTR_STRONG_T`, 11). A taken outcome moves the counter one state toward strong-taken, and a not-taken outcome moves it one state toward strong-not-taken. Both end states saturate.

Top module: `branch_predictor`

## Requirements
- R1: When the target cache misses for `fetch_pc`, or the counter for `fetch_pc` is in 00 or 01, and `flush` is low, `fetch_npc` equals `fetch_pc`+4 and `pred_taken` is 0.
- R2: After reset every counter is 01 (weak-not-taken) and every target entry is invalid, so every fetch address predicts PC+4.
- R3: Each counter is a 2-bit saturating state: a taken resolve moves it up one step, stopping at 11, and a not-taken resolve moves it down one step, stopping at 00. A counter predicts taken when its upper bit is 1, so a counter in 11 needs two not-taken resolves before it predicts not taken.
- R4: The direction counter is selected by PC bits [7:2], so two branches whose PCs differ only above bit 7 share, and both train, one counter.
- R5: The target cache has 16 entries. It is indexed by PC bits [5:2] and tagged by PC bits [31:6]. A hit needs a valid entry with a matching tag. An entry is written only by a valid taken resolve, which sets it valid and stores the tag and the target; a not-taken resolve leaves the cache unchanged.
- R6: When the target cache hits and the counter is in 10 or 11, `pred_taken` is 1 and, if `flush` is low, `fetch_npc` equals the cached target in the same cycle.
- R7: A mispredict is a valid resolve whose real next PC differs from `res_pred_npc`. The real next PC is `res_target` if the branch was taken, or `res_pc`+4 if it was not. A mispredict raises `flush` in the same cycle.
- R8: While `flush` is high, `fetch_npc` is the real next PC of the resolving branch, whatever the fetch lookup gives.
- R9: When a fetch lookup and a resolve update touch the same entry in one cycle, the lookup returns the contents from before the update, and the new contents show from the next cycle on.
- R10: Counters train on every valid resolve, whether the prediction was right or wrong. When `res_valid` is low, no counter or target entry changes and `flush` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| fetch_npc | output | 32 | Next fetch address (predicted, or the correction on flush) |
| pred_taken | output | 1 | Lookup for `fetch_pc` predicts taken with a cached target |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch |
| res_target | input | 32 | Actual target of the resolving branch |
| res_pred_npc | input | 32 | Next PC that fetch followed after the resolving branch |
| flush | output | 1 | Mispredict: flush younger work and restart at `fetch_npc` |

## Verification
Some properties are checked on every cycle by the assertions:
- Counters move only in the direction of the resolved outcome.
- A taken resolve leaves a valid entry with its tag and target.
- The valid set of the target cache is frozen while nothing resolves.
- A flush appears only with a valid resolve, and it always moves fetch off the path that was followed.

Other behaviour can only be shown by the bench's scenarios, which follow a branch through its history:
- the two-step hysteresis out of a strong state;
- aliasing between PCs that share counter index bits but differ in tag;
- a lookup that returns old contents while the same entry is being written;
- the redirect address replacing an unrelated fetch lookup.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Direction counter states; the upper bit is the taken prediction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    localparam int unsigned BP_PC_W   = 32;
    localparam int unsigned BP_INSN_B = 4;

endpackage

// File: rtl/bp_history_table.sv
module bp_history_table
    import bp_pkg::*;
#(
    parameter int unsigned PC_W  = BP_PC_W,
    parameter int unsigned IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] look_pc,
    output logic            look_taken,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int unsigned ENTRIES = 1 << IDX_W;

    ctr_state_e             ctr_q [ENTRIES];
    ctr_state_e             ctr_nxt;
    ctr_state_e             look_state;
    logic [IDX_W-1:0]       look_idx;
    logic [IDX_W-1:0]       upd_idx;

    assign look_idx = look_pc[IDX_W+1:2];
    assign upd_idx  = upd_pc[IDX_W+1:2];

    // State register array: one counter per entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i] <= CTR_WEAK_NT;
            end
        end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr_nxt;
        end
    end

    // Transition logic for the entry being trained.
    always_comb begin
        ctr_nxt = ctr_q[upd_idx];
        unique case (ctr_q[upd_idx])
            CTR_STRONG_NT: ctr_nxt = upd_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   ctr_nxt = upd_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    ctr_nxt = upd_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  ctr_nxt = upd_taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       ctr_nxt = CTR_WEAK_NT;
        endcase
    end

    // Output decode for the fetch lookup (reads pre-update contents).
    always_comb begin
        look_state = ctr_q[look_idx];
        unique case (look_state)
            CTR_WEAK_T, CTR_STRONG_T:   look_taken = 1'b1;
            CTR_STRONG_NT, CTR_WEAK_NT: look_taken = 1'b0;
            default:                    look_taken = 1'b0;
        endcase
    end

    // R3: a taken outcome never lowers the trained counter.
    assert_train_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken) |=> (ctr_q[$past(upd_idx)] >= $past(ctr_q[upd_idx])));

    // R3: a not-taken outcome never raises the trained counter.
    assert_train_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken) |=> (ctr_q[$past(upd_idx)] <= $past(ctr_q[upd_idx])));

    // R3: strong-taken saturates on a further taken outcome.
    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && ctr_q[upd_idx] == CTR_STRONG_T)
        |=> (ctr_q[$past(upd_idx)] == CTR_STRONG_T));

endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer
    import bp_pkg::*;
#(
    parameter int unsigned PC_W  = BP_PC_W,
    parameter int unsigned IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] look_pc,
    output logic            look_hit,
    output logic [PC_W-1:0] look_tgt,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_tgt
);

    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned TAG_LSB = IDX_W + 2;
    localparam int unsigned TAG_W   = PC_W - TAG_LSB;

    logic [ENTRIES-1:0]     valid_q;
    logic [TAG_W-1:0]       tag_q [ENTRIES];
    logic [PC_W-1:0]        tgt_q [ENTRIES];

    logic [IDX_W-1:0]       look_idx;
    logic [IDX_W-1:0]       wr_idx;
    logic [TAG_W-1:0]       look_tag;
    logic [TAG_W-1:0]       wr_tag;

    assign look_idx = look_pc[IDX_W+1:2];
    assign look_tag = look_pc[PC_W-1:TAG_LSB];
    assign wr_idx   = wr_pc[IDX_W+1:2];
    assign wr_tag   = wr_pc[PC_W-1:TAG_LSB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                tgt_q[i] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            tgt_q[wr_idx]   <= wr_tgt;
        end
    end

    always_comb begin
        look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
        look_tgt = tgt_q[look_idx];
    end

    // R5: a fill leaves a valid entry carrying the written tag and target.
    assert_fill_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)]
                   && tag_q[$past(wr_idx)] == $past(wr_tag)
                   && tgt_q[$past(wr_idx)] == $past(wr_tgt)));

    // R10: no write request means the valid set does not move.
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));

endmodule

// File: rtl/bp_resolve_check.sv
module bp_resolve_check
    import bp_pkg::*;
#(
    parameter int unsigned PC_W = BP_PC_W
) (
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic [PC_W-1:0] res_pred_npc,
    output logic            mispredict,
    output logic [PC_W-1:0] fix_pc
);

    logic [PC_W-1:0] fall_pc;

    always_comb begin
        fall_pc    = res_pc + PC_W'(BP_INSN_B);
        fix_pc     = res_taken ? res_target : fall_pc;
        mispredict = res_valid && (fix_pc != res_pred_npc);
    end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
    import bp_pkg::*;
#(
    parameter int unsigned PC_W      = BP_PC_W,
    parameter int unsigned BHT_IDX_W = 6,
    parameter int unsigned BTB_IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] fetch_npc,
    output logic            pred_taken,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic [PC_W-1:0] res_pred_npc,
    output logic            flush
);

    logic            dir_taken;
    logic            tgt_hit;
    logic [PC_W-1:0] tgt_pc;
    logic            mispredict;
    logic [PC_W-1:0] fix_pc;
    logic            btb_wr;
    logic [PC_W-1:0] seq_pc;

    assign btb_wr = res_valid && res_taken;
    assign seq_pc = fetch_pc + PC_W'(BP_INSN_B);

    bp_history_table #(
        .PC_W  (PC_W),
        .IDX_W (BHT_IDX_W)
    ) u_bht (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_pc    (fetch_pc),
        .look_taken (dir_taken),
        .upd_en     (res_valid),
        .upd_pc     (res_pc),
        .upd_taken  (res_taken)
    );

    bp_target_buffer #(
        .PC_W  (PC_W),
        .IDX_W (BTB_IDX_W)
    ) u_btb (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_pc  (fetch_pc),
        .look_hit (tgt_hit),
        .look_tgt (tgt_pc),
        .wr_en    (btb_wr),
        .wr_pc    (res_pc),
        .wr_tgt   (res_target)
    );

    bp_resolve_check #(
        .PC_W (PC_W)
    ) u_chk (
        .res_valid    (res_valid),
        .res_pc       (res_pc),
        .res_taken    (res_taken),
        .res_target   (res_target),
        .res_pred_npc (res_pred_npc),
        .mispredict   (mispredict),
        .fix_pc       (fix_pc)
    );

    always_comb begin
        pred_taken = tgt_hit && dir_taken;
        flush      = mispredict;
        if (mispredict) begin
            fetch_npc = fix_pc;
        end else if (pred_taken) begin
            fetch_npc = tgt_pc;
        end else begin
            fetch_npc = seq_pc;
        end
    end

    // R7: a flush is only ever raised by a resolving branch.
    assert_flush_needs_resolve_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> res_valid);

    // R8: on a flush, fetch leaves the path that was followed.
    assert_redirect_leaves_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (fetch_npc != res_pred_npc));

endmodule

// File: tb/test_branch_predictor.sv
`timescale 1ns/1ps
module test_branch_predictor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_pc;
    logic [31:0] fetch_npc;
    logic        pred_taken;
    logic        res_valid;
    logic [31:0] res_pc;
    logic        res_taken;
    logic [31:0] res_target;
    logic [31:0] res_pred_npc;
    logic        flush;

    always #2.5 clk = ~clk;

    branch_predictor i_branch_predictor (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .fetch_npc    (fetch_npc),
        .pred_taken   (pred_taken),
        .res_valid    (res_valid),
        .res_pc       (res_pc),
        .res_taken    (res_taken),
        .res_target   (res_target),
        .res_pred_npc (res_pred_npc),
        .flush        (flush)
    );

    // Reference state built from the requirements.
    logic [1:0]  m_ctr [64];
    logic        m_val [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 0;

    function automatic logic m_taken(input logic [31:0] pc);
        logic hit;
        hit = m_val[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
        return hit && m_ctr[pc[7:2]][1];
    endfunction

    function automatic logic [31:0] m_npc(input logic [31:0] pc);
        return m_taken(pc) ? m_tgt[pc[5:2]] : pc + 32'd4;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
        for (int i = 0; i < 16; i++) begin
            m_val[i] = 1'b0;
            m_tag[i] = '0;
            m_tgt[i] = '0;
        end
    endtask

    task automatic m_update(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        if (tk) begin
            if (m_ctr[pc[7:2]] != 2'b11) m_ctr[pc[7:2]] = m_ctr[pc[7:2]] + 2'd1;
            m_val[pc[5:2]] = 1'b1;
            m_tag[pc[5:2]] = pc[31:6];
            m_tgt[pc[5:2]] = tgt;
        end else begin
            if (m_ctr[pc[7:2]] != 2'b00) m_ctr[pc[7:2]] = m_ctr[pc[7:2]] - 2'd1;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check combinational outputs, then advance the model.
    task automatic step(input string req, input logic [31:0] fpc, input logic rv,
                        input logic [31:0] rpc, input logic rt,
                        input logic [31:0] rtgt, input logic [31:0] rpn);
        logic [31:0] real_npc;
        logic        mis;
        @(negedge clk);
        fetch_pc     = fpc;
        res_valid    = rv;
        res_pc       = rpc;
        res_taken    = rt;
        res_target   = rtgt;
        res_pred_npc = rpn;
        #1;
        real_npc = rt ? rtgt : rpc + 32'd4;
        mis      = rv && (real_npc != rpn);
        chk(req, "flush", {31'd0, flush}, {31'd0, mis});
        chk(req, "pred_taken", {31'd0, pred_taken}, {31'd0, m_taken(fpc)});
        chk(req, "fetch_npc", fetch_npc, mis ? real_npc : m_npc(fpc));
        if (rv) m_update(rpc, rt, rtgt);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, t, b, t2, d, e, t4, f;
        void'($urandom(32'd1234));
        m_reset();
        rst_n = 1'b0;
        fetch_pc = '0; res_valid = 0; res_pc = '0; res_taken = 0;
        res_target = '0; res_pred_npc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: nothing cached after reset
        step("R2", 32'h0000_2010, 0, '0, 0, '0, '0);
        step("R2", 32'h8000_0ffc, 0, '0, 0, '0, '0);

        a = 32'h0000_2010; t = 32'h0000_3000;
        // R8: mispredict overrides an unrelated fetch lookup
        step("R8", 32'h0000_5000, 1, a, 1, t, a + 4);
        // R6: counter now weak-taken with cached target
        step("R6", a, 0, '0, 0, '0, '0);

        // R9: same-entry lookup and fill in one cycle
        b = 32'h0000_2024; t2 = 32'h0000_4400;
        step("R9", b, 1, b, 1, t2, b + 4);
        step("R9", b, 0, '0, 0, '0, '0);

        // R3: train to strong taken, then hysteresis
        step("R3", 32'h0000_6000, 1, a, 1, t, t);
        d = a + 32'h40;
        // R5: not-taken resolve on same cache index leaves entry intact
        step("R5", 32'h0000_6000, 1, d, 0, 32'h0000_7700, d + 4);
        step("R5", a, 0, '0, 0, '0, '0);
        step("R5", d, 0, '0, 0, '0, '0);
        step("R3", a, 1, a, 0, '0, t);
        step("R3", a, 0, '0, 0, '0, '0);
        step("R3", a, 1, a, 0, '0, t);
        step("R3", a, 0, '0, 0, '0, '0);

        // R4: alias sharing counter index, differing tag
        e = a + 32'h100; t4 = 32'h0000_9100;
        step("R4", e, 1, e, 1, t4, e + 4);
        step("R4", e, 0, '0, 0, '0, '0);
        step("R5", a, 0, '0, 0, '0, '0);
        step("R4", e, 1, a, 0, '0, a + 4);
        step("R4", e, 0, '0, 0, '0, '0);

        // R10: inputs ignored while res_valid is low
        f = 32'h0000_a008;
        step("R10", f, 0, f, 1, 32'h0000_bb00, 32'h1234_5678);
        step("R10", f, 0, '0, 0, '0, '0);

        // R1 / R6 / R7: random traffic over a small address pool
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] fp, rp, rg, pn;
            logic        rv, rt;
            string       tag;
            fp = 32'h0000_1000 + ($urandom_range(0, 15) << 2)
                 + ($urandom_range(0, 2) << 8);
            rp = 32'h0000_1000 + ($urandom_range(0, 15) << 2)
                 + ($urandom_range(0, 2) << 8);
            rv = ($urandom_range(0, 3) != 0);
            rt = $urandom_range(0, 1);
            rg = 32'h0002_0000 + ($urandom_range(0, 7) << 4);
            pn = ($urandom_range(0, 9) < 7) ? m_npc(rp) : (rt ? rp + 4 : rg);
            if (rv && ((rt ? rg : rp + 4) != pn)) tag = "R7";
            else if (m_taken(fp))                tag = "R6";
            else                                 tag = "R1";
            step(tag, fp, rv, rp, rt, rg, pn);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule